// File: doc/BRIEF.md
# Activity load monitor with band-exit interrupts

This block reports how busy an engine is. It splits time into back-to-back sampling windows of a programmable number of clock cycles. In each window it counts the cycles in which the engine's activity input is high. When a window closes it turns that count into a load figure in thousandths (0 means idle for the whole window, 1000 means busy in every cycle) and publishes it with a one-cycle strobe.

Each new load figure is compared against an upper and a lower watermark. A load strictly above the upper mark or strictly below the lower mark sets a sticky status bit, and an interrupt request is raised for each status bit whose enable is set. Software clears status bits by writing ones. After a scaling action is reported on the scaling-done input, band exits are ignored for a programmable hold-off given in microseconds. A prescaler sized by the reference clock rate turns microseconds into cycles.

The register interface is a plain single-cycle write port and a combinational read port, both addressed by a 3-bit address.

Top module: `busy_gauge`

## Requirements
- R1: Windows follow one another without gaps. The active count of a window covers exactly the cycles of that window, and every window is as long as the effective window length.
- R2: When a window closes, the load becomes floor(active x 1000 / window length). It is driven on `load_o` and can be read at address 6, bits [9:0]. Its range is 0 to 1000.
- R3: `load_valid_o` is a single-cycle pulse. It fires once per window, at most 12 cycles after the window closes, and `load_o` changes in that same cycle.
- R4: A window length register value below 12 is treated as 12.
- R5: A pulse on `scale_done_i` starts a hold-off of (hold-off register) x REF_MHZ cycles. During the hold-off, load results update `load_o` but set no status bit. A hold-off value of 0 suppresses nothing.
- R6: `irq_o` is high exactly when some status bit is set and its enable is set. The enable register is at address 5: bit 0 enables the high event, bit 1 enables the low event.
- R7: The status register is at address 4: bit 0 is the high event, bit 1 is the low event. A load strictly greater than the upper mark sets bit 0. Otherwise, a load strictly smaller than the lower mark sets bit 1. The high event wins even when the marks are inverted.
- R8: Writing the status address clears each bit written as 1 and leaves bits written as 0 unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R9: Register addresses and reset values:
  - address 0: window length, reset RST_WIN
  - address 1: upper mark, reset 900
  - address 2: lower mark, reset 100
  - address 3: hold-off in microseconds, reset 0
  - load, status and enables reset to 0, and `load_valid_o` and `irq_o` reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Engine activity, sampled every cycle |
| scale_done_i | input | 1 | Pulse: a scaling action has just completed |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| load_o | output | 10 | Latest load in thousandths |
| load_valid_o | output | 1 | Pulse: new load published |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with WIN_W=8, HOLD_W=8, REF_MHZ=4 and RST_WIN=40.

Windows of 20, 33 and 50 cycles are short enough to sweep every active count from 0 to the window length, and each result is checked against the exact rounded-down per-mille value. With 4 cycles per microsecond, a 10-microsecond hold-off lasts 40 cycles. That is two windows, so one suppressed result and a later recorded one both fit in a short run.

Clamped lengths, marks equal to the load, inverted marks, enable masking and write-one-to-clear are all reached with the same small setup.

// File: rtl/busy_gauge_pkg.sv
package busy_gauge_pkg;
    localparam int LOAD_W    = 10;
    localparam int PERMILLE  = 1000;
    localparam int DIV_STEPS = LOAD_W;
    localparam int MIN_WIN   = DIV_STEPS + 2;
    localparam int REG_W     = 16;
    localparam int HI_RST    = 900;
    localparam int LO_RST    = 100;

    localparam logic [2:0] A_WIN   = 3'd0;
    localparam logic [2:0] A_HI    = 3'd1;
    localparam logic [2:0] A_LO    = 3'd2;
    localparam logic [2:0] A_HOLD  = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;
    localparam logic [2:0] A_IRQEN = 3'd5;
    localparam logic [2:0] A_LOAD  = 3'd6;

    localparam int BIT_HI = 0;
    localparam int BIT_LO = 1;
endpackage

// File: rtl/bg_window.sv
module bg_window
    import busy_gauge_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [WIN_W-1:0] len_i,
    output logic             close_o,
    output logic [WIN_W-1:0] act_o,
    output logic [WIN_W-1:0] tot_o
);
    localparam logic [WIN_W-1:0] ONE     = WIN_W'(1);
    localparam logic [WIN_W-1:0] MIN_LEN = WIN_W'(MIN_WIN);

    typedef struct packed {
        logic [WIN_W-1:0] cnt;
        logic [WIN_W-1:0] act;
        logic [WIN_W-1:0] act_cap;
        logic [WIN_W-1:0] tot_cap;
        logic             close;
    } win_t;

    win_t             s_d, s_q;
    logic [WIN_W-1:0] eff_len;
    logic [WIN_W-1:0] act_inc;

    always_comb begin
        eff_len = (len_i < MIN_LEN) ? MIN_LEN : len_i;
        act_inc = s_q.act + WIN_W'(busy_i);
        s_d       = s_q;
        s_d.close = 1'b0;
        if (s_q.cnt >= eff_len - ONE) begin
            s_d.close   = 1'b1;
            s_d.act_cap = act_inc;
            s_d.tot_cap = eff_len;
            s_d.cnt     = '0;
            s_d.act     = '0;
        end else begin
            s_d.cnt = s_q.cnt + ONE;
            s_d.act = act_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign close_o = s_q.close;
    assign act_o   = s_q.act_cap;
    assign tot_o   = s_q.tot_cap;
endmodule

// File: rtl/bg_divider.sv
module bg_divider
    import busy_gauge_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WIN_W-1:0]  act_i,
    input  logic [WIN_W-1:0]  tot_i,
    output logic              done_o,
    output logic [LOAD_W-1:0] res_o
);
    localparam int NUM_W  = WIN_W + LOAD_W;
    localparam int STEP_W = $clog2(DIV_STEPS + 1);

    typedef struct packed {
        logic [NUM_W-1:0]  rem;
        logic [WIN_W-1:0]  den;
        logic [LOAD_W-1:0] quo;
        logic [STEP_W-1:0] step;
        logic              done;
        logic [LOAD_W-1:0] res;
    } div_t;

    div_t              s_d, s_q;
    logic [NUM_W-1:0]  trial;
    logic [STEP_W-1:0] idx;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = '0;
        idx      = '0;
        if (start_i) begin
            s_d.rem  = NUM_W'(act_i) * NUM_W'(PERMILLE);
            s_d.den  = tot_i;
            s_d.quo  = '0;
            s_d.step = STEP_W'(DIV_STEPS);
        end else if (s_q.step != '0) begin
            idx   = s_q.step - STEP_W'(1);
            trial = NUM_W'(s_q.den) << idx;
            if (s_q.rem >= trial) begin
                s_d.rem      = s_q.rem - trial;
                s_d.quo[idx] = 1'b1;
            end
            s_d.step = idx;
            if (idx == '0) begin
                s_d.done = 1'b1;
                s_d.res  = s_d.quo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign res_o  = s_q.res;
endmodule

// File: rtl/bg_holdoff.sv
module bg_holdoff #(
    parameter int HOLD_W  = 16,
    parameter int REF_MHZ = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [HOLD_W-1:0] us_i,
    output logic              active_o
);
    localparam int               PRE_W    = (REF_MHZ > 1) ? $clog2(REF_MHZ) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_MHZ - 1);

    typedef struct packed {
        logic [HOLD_W-1:0] us;
        logic [PRE_W-1:0]  pre;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.us  = us_i;
            s_d.pre = '0;
        end else if (s_q.us != '0) begin
            if (s_q.pre == PRE_LAST) begin
                s_d.pre = '0;
                s_d.us  = s_q.us - HOLD_W'(1);
            end else begin
                s_d.pre = s_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = (s_q.us != '0);
endmodule

// File: rtl/busy_gauge.sv
module busy_gauge
    import busy_gauge_pkg::*;
#(
    parameter int WIN_W   = 16,
    parameter int HOLD_W  = 16,
    parameter int REF_MHZ = 100,
    parameter int RST_WIN = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              scale_done_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [LOAD_W-1:0] load_o,
    output logic              load_valid_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [LOAD_W-1:0] hi;
        logic [LOAD_W-1:0] lo;
        logic [HOLD_W-1:0] hold;
        logic [1:0]        en;
        logic [1:0]        st;
        logic [LOAD_W-1:0] load;
        logic              valid;
    } regs_t;

    regs_t             r_d, r_q;
    logic              win_close;
    logic [WIN_W-1:0]  win_act;
    logic [WIN_W-1:0]  win_tot;
    logic              div_done;
    logic [LOAD_W-1:0] div_res;
    logic              hold_active;
    logic [1:0]        status_w;
    logic [HOLD_W-1:0] hold_us_w;

    bg_window #(.WIN_W(WIN_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_i),
        .len_i   (r_q.win),
        .close_o (win_close),
        .act_o   (win_act),
        .tot_o   (win_tot)
    );

    bg_divider #(.WIN_W(WIN_W)) u_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (win_close),
        .act_i   (win_act),
        .tot_i   (win_tot),
        .done_o  (div_done),
        .res_o   (div_res)
    );

    bg_holdoff #(.HOLD_W(HOLD_W), .REF_MHZ(REF_MHZ)) u_holdoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (scale_done_i),
        .us_i      (r_q.hold),
        .active_o  (hold_active)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_WIN:   r_d.win  = wr_data_i[WIN_W-1:0];
                A_HI:    r_d.hi   = wr_data_i[LOAD_W-1:0];
                A_LO:    r_d.lo   = wr_data_i[LOAD_W-1:0];
                A_HOLD:  r_d.hold = wr_data_i[HOLD_W-1:0];
                A_IRQEN: r_d.en   = wr_data_i[1:0];
                A_STAT:  r_d.st   = r_q.st & ~wr_data_i[1:0];
                default: ;
            endcase
        end
        if (div_done) begin
            r_d.load  = div_res;
            r_d.valid = 1'b1;
            if (!hold_active) begin
                if (div_res > r_q.hi)      r_d.st[BIT_HI] = 1'b1;
                else if (div_res < r_q.lo) r_d.st[BIT_LO] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.win <= WIN_W'(RST_WIN);
            r_q.hi  <= LOAD_W'(HI_RST);
            r_q.lo  <= LOAD_W'(LO_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_WIN:   rd_data_o = REG_W'(r_q.win);
            A_HI:    rd_data_o = REG_W'(r_q.hi);
            A_LO:    rd_data_o = REG_W'(r_q.lo);
            A_HOLD:  rd_data_o = REG_W'(r_q.hold);
            A_STAT:  rd_data_o = REG_W'(r_q.st);
            A_IRQEN: rd_data_o = REG_W'(r_q.en);
            A_LOAD:  rd_data_o = REG_W'(r_q.load);
            default: rd_data_o = '0;
        endcase
    end

    assign status_w     = r_q.st;
    assign hold_us_w    = r_q.hold;
    assign load_o       = r_q.load;
    assign load_valid_o = r_q.valid;
    assign irq_o        = |(r_q.st & r_q.en);
endmodule

// File: rtl/busy_gauge_chk.sv
module busy_gauge_chk
    import busy_gauge_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scale_done_i,
    input logic              wr_en_i,
    input logic [2:0]        wr_addr_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [LOAD_W-1:0] load_o,
    input logic              load_valid_o,
    input logic              irq_o,
    input logic [1:0]        status_w,
    input logic [HOLD_W-1:0] hold_us_w
);
    AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid_o |-> (load_o <= LOAD_W'(PERMILLE))); // R2

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid_o |=> !load_valid_o); // R3

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scale_done_i, 2) && ($past(hold_us_w, 2) != '0))
            |-> ((status_w & ~$past(status_w)) == 2'b00)); // R5

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (load_valid_o || $past(wr_en_i && (wr_addr_i == A_IRQEN)))); // R6

    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & ~$past(status_w)) != 2'b11)); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[BIT_HI]) && !load_valid_o)
            |-> !status_w[BIT_HI]); // R8
endmodule

bind busy_gauge busy_gauge_chk #(.HOLD_W(HOLD_W)) u_chk (.*);

// File: tb/busy_gauge_bench.sv
module busy_gauge_bench;
    import busy_gauge_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy_i = 1'b0;
    logic        scale_done_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic [9:0]  load_o;
    logic        load_valid_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;
    int cyc    = 0;
    int pat_len = 1;
    int pat_k   = 0;

    busy_gauge #(.WIN_W(8), .HOLD_W(8), .REF_MHZ(4), .RST_WIN(40)) u_busy_gauge (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .scale_done_i (scale_done_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .load_o       (load_o),
        .load_valid_o (load_valid_o),
        .irq_o        (irq_o)
    );

    always #2 clk = ~clk;

    // periodic activity: any pat_len consecutive cycles hold exactly pat_k busy cycles
    always @(negedge clk) begin
        cyc    = cyc + 1;
        busy_i = ((cyc % pat_len) < pat_k);
    end

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog expired act=%0d exp=%0d", wd, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = a;
        wr_data_i = 16'(d);
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr_i = a;
        #1;
        v = int'(rd_data_o);
    endtask

    task automatic wait_valid();
        @(negedge clk);
        while (!load_valid_o) @(negedge clk);
    endtask

    task automatic settle(input int k);
        pat_len = 20;
        pat_k   = k;
        repeat (3) wait_valid();
        wr(A_STAT, 3);
        wait_valid();
    endtask

    initial begin
        int v;
        int lens [3] = '{20, 33, 50};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(int'(load_o), 0, "R9 load_o after reset");
        chk(int'(load_valid_o), 0, "R9 load_valid_o after reset");
        chk(int'(irq_o), 0, "R9 irq_o after reset");
        rd(A_WIN, v);  chk(v, 40, "R9 window reset");
        rd(A_HI, v);   chk(v, 900, "R9 upper mark reset");
        rd(A_LO, v);   chk(v, 100, "R9 lower mark reset");
        rd(A_HOLD, v); chk(v, 0, "R9 hold-off reset");
        rd(A_STAT, v); chk(v, 0, "R9 status reset");
        rd(A_IRQEN, v); chk(v, 0, "R9 enable reset");

        // full sweep of active counts for several window lengths
        foreach (lens[i]) begin
            wr(A_WIN, lens[i]);
            for (int k = 0; k <= lens[i]; k++) begin
                pat_len = lens[i];
                pat_k   = k;
                repeat (3) wait_valid();
                chk(int'(load_o), (k * 1000) / lens[i], "R1 R2 load sweep");
            end
        end
        pat_len = 50;
        pat_k   = 17;
        repeat (3) wait_valid();
        rd(A_LOAD, v);
        chk(v, 340, "R2 load readback");

        // pulse width of the strobe
        @(negedge clk);
        chk(int'(load_valid_o), 0, "R3 strobe lasts one cycle");

        // window length clamp
        wr(A_WIN, 3);
        pat_len = 12;
        pat_k   = 5;
        repeat (3) wait_valid();
        chk(int'(load_o), 416, "R4 short window clamped to 12");
        pat_k = 12;
        repeat (3) wait_valid();
        chk(int'(load_o), 1000, "R4 clamped window fully busy");

        // watermarks
        wr(A_WIN, 20);
        wr(A_HI, 600);
        wr(A_LO, 300);
        wr(A_IRQEN, 3);
        settle(14);
        rd(A_STAT, v); chk(v, 1, "R7 load 700 above upper mark");
        chk(int'(irq_o), 1, "R6 irq from high event");
        wr(A_STAT, 0);
        rd(A_STAT, v); chk(v, 1, "R8 writing zeros keeps status");
        wr(A_STAT, 1);
        rd(A_STAT, v); chk(v, 0, "R8 write one clears high bit");
        chk(int'(irq_o), 0, "R8 irq drops after clear");

        settle(4);
        rd(A_STAT, v); chk(v, 2, "R7 load 200 below lower mark");
        wr(A_IRQEN, 1);
        chk(int'(irq_o), 0, "R6 low event masked");
        wr(A_IRQEN, 2);
        chk(int'(irq_o), 1, "R6 low event enabled");
        wr(A_IRQEN, 3);

        settle(9);
        rd(A_STAT, v); chk(v, 0, "R7 load 450 inside band");
        settle(12);
        rd(A_STAT, v); chk(v, 0, "R7 load equal to upper mark");
        settle(6);
        rd(A_STAT, v); chk(v, 0, "R7 load equal to lower mark");
        settle(13);
        rd(A_STAT, v); chk(v, 1, "R7 load 650 just above upper");

        // inverted marks: high wins
        wr(A_HI, 100);
        wr(A_LO, 900);
        settle(10);
        rd(A_STAT, v); chk(v, 1, "R7 high event takes priority");

        // hold-off: 10 us x 4 cycles = 40 cycles
        wr(A_HI, 600);
        wr(A_LO, 300);
        wr(A_HOLD, 10);
        pat_k = 14;
        repeat (3) wait_valid();
        wr(A_STAT, 3);
        @(negedge clk); scale_done_i = 1'b1;
        @(negedge clk); scale_done_i = 1'b0;
        wait_valid();
        chk(int'(load_o), 700, "R5 load still updates in hold-off");
        rd(A_STAT, v); chk(v, 0, "R5 event suppressed in hold-off");
        chk(int'(irq_o), 0, "R5 no irq in hold-off");
        repeat (3) wait_valid();
        rd(A_STAT, v); chk(v, 1, "R5 event recorded after hold-off");

        wr(A_HOLD, 0);
        wait_valid();
        wr(A_STAT, 3);
        @(negedge clk); scale_done_i = 1'b1;
        @(negedge clk); scale_done_i = 1'b0;
        wait_valid();
        rd(A_STAT, v); chk(v, 1, "R5 zero hold-off suppresses nothing");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule